// File: doc/BRIEF.md
# SPI Serial Memory Command Front-End

This block is the slave-side command interpreter for a byte-wide serial nonvolatile memory with a 17-bit byte address space. It oversamples the serial clock, active-low select, serial input and the active-low pause input in the system clock domain. From that stream it takes an 8-bit instruction, decodes it, gathers a three-byte address and then either streams array or status bytes out on a tri-stateable serial output, or forwards incoming bytes as single-cycle strobes to a page-write engine and a protection unit.

The array is reached through a one-cycle synchronous read port. Write enable bookkeeping, protection checks and cell programming belong to neighbouring units. This block only emits the strobes and the end-of-write marker those units need. A busy input from the write engine restricts the command set while an internal write runs.

Top module: `spi_mem_frontend`

## Requirements
- R1: Both serial modes work: clock idle low (mode 0) and clock idle high (mode 3). The input bit is taken on the rising serial clock edge and the output bit changes on the falling edge. Every instruction, address and data byte travels most significant bit first.
- R2: The instruction byte must have its upper nibble equal to 0. Bit 3 is don't-care, and bits 2..0 select the command: 110 pulses wen_set_o, 100 pulses wen_clr_o, 101 reads status, 001 writes status, 011 reads the array, 010 writes the array.
- R3: Array commands take three address bytes. The address is the low 17 bits of those 24 bits, and bits 23..17 are ignored.
- R4: An array read raises rd_req_o with addr_o, takes rd_data_i one cycle later, and streams bytes without a gap. After each byte the address increments, and it wraps from 0x1FFFF to 0x00000.
- R5: A status read sends status_i on every byte for as long as the select stays active.
- R6: A status write passes its first data byte on data_o with one sr_wr_o pulse. Later bytes are ignored.
- R7: An array write gives one pg_wr_o pulse per data byte, with addr_o and data_o valid. Between bytes only addr_o bits 6..0 increment, wrapping inside the 128-byte page. Raising the select after at least one data byte pulses pg_end_o.
- R8: A byte that does not decode under R2 locks the block. No strobe fires and so_oe_o stays low until the next falling edge of the select.
- R9: While busy_i is high at instruction decode, every instruction except a status read is dropped with no strobe.
- R10: A falling or rising edge of hold_ni takes effect only while the serial clock is low. While paused, so_oe_o is low, input bits and clock edges are ignored, and the transfer resumes exactly where it stopped.
- R11: While the select is high, so_oe_o is low and serial clock activity has no effect.
- R12: so_oe_o is high only during the output phase of a status or array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the master |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Output enable for so_o (low means high impedance) |
| busy_i | input | 1 | Internal write cycle running |
| status_i | input | 8 | Status byte to send on a status read |
| rd_req_o | output | 1 | Array read request |
| addr_o | output | 17 | Byte address for reads and page writes |
| rd_data_i | input | 8 | Array read data, one cycle after rd_req_o |
| data_o | output | 8 | Write byte for sr_wr_o or pg_wr_o |
| wen_set_o | output | 1 | Set-write-enable strobe |
| wen_clr_o | output | 1 | Clear-write-enable strobe |
| sr_wr_o | output | 1 | Status write strobe |
| pg_wr_o | output | 1 | Page data byte strobe |
| pg_end_o | output | 1 | Array write finished by select release |

## Verification
A table of reads mixes both clock modes, set and clear bit 3 in the opcode, and junk in address bits 23..17. Start points near 0x1FFFF separate correct wraparound from a carry into ignored bits. Directed writes start at page offset 0x7E to show that the low bits wrap while the page stays fixed. Pauses are placed inside a byte, with the clock toggling and SI inverted during the pause. This tells a resumed shift apart from one that counted the ignored edges. Lockout, busy filtering and idle-select clocking send bytes that would decode as valid commands and check that no strobe appears.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic [2:0] {
    OP_SETWE, OP_CLRWE, OP_RDST, OP_WRST, OP_RDARR, OP_WRARR, OP_BAD
  } op_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_RDOUT, PH_STOUT, PH_STIN, PH_WRDATA, PH_SKIP, PH_LOCK
  } phase_e;

  // bit 3 is don't-care
  function automatic op_e op_decode(input logic [7:0] b);
    op_e r;
    if (b[7:4] != 4'h0) r = OP_BAD;
    else begin
      case (b[2:0])
        3'b110:  r = OP_SETWE;
        3'b100:  r = OP_CLRWE;
        3'b101:  r = OP_RDST;
        3'b001:  r = OP_WRST;
        3'b011:  r = OP_RDARR;
        3'b010:  r = OP_WRARR;
        default: r = OP_BAD;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign q_o    = stg_q[STAGES-1];
  assign rise_o = q_o & ~prev_q;
  assign fall_o = ~q_o & prev_q;

endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [DW-1:0] byte_o,
  output logic          done_o
);

  localparam int CW = $clog2(DW);

  logic [DW-2:0] sh_q;
  logic [CW-1:0] cnt_q;

  assign byte_o = {sh_q, bit_i};
  assign done_o = shift_i && (cnt_q == CW'(DW-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= byte_o[DW-2:0];
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          shift_i,
  input  logic [DW-1:0] load_i,
  output logic          so_o,
  output logic          need_o
);

  localparam int CW = $clog2(DW);

  logic [DW-2:0] sh_q;
  logic [CW-1:0] cnt_q;

  // a new byte is taken from load_i on this edge
  assign need_o = shift_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      so_o  <= 1'b0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
      so_o  <= 1'b0;
    end else if (need_o) begin
      so_o  <= load_i[DW-1];
      sh_q  <= load_i[DW-2:0];
      cnt_q <= CW'(DW-1);
    end else if (shift_i) begin
      so_o  <= sh_q[DW-2];
      sh_q  <= {sh_q[DW-3:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int ADDR_BYTES  = 3,
  parameter int PAGE_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  input  logic              hold_ni,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic [7:0]        rd_data_i,
  output logic [7:0]        data_o,
  output logic              wen_set_o,
  output logic              wen_clr_o,
  output logic              sr_wr_o,
  output logic              pg_wr_o,
  output logic              pg_end_o
);

  localparam int AB_W = $clog2(ADDR_BYTES + 1);
  localparam int I_SCK = 0, I_CS = 1, I_SI = 2, I_HOLD = 3;

  logic [3:0] sy_q, sy_rise, sy_fall;

  spi_fe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({hold_ni, si_i, cs_ni, sck_i}),
    .q_o    (sy_q),
    .rise_o (sy_rise),
    .fall_o (sy_fall)
  );

  logic sck_s, cs_n_s, si_s;
  logic sck_rise, sck_fall, cs_rise, cs_fall, hold_rise, hold_fall;
  logic unused_edges;

  assign sck_s        = sy_q[I_SCK];
  assign cs_n_s       = sy_q[I_CS];
  assign si_s         = sy_q[I_SI];
  assign sck_rise     = sy_rise[I_SCK];
  assign sck_fall     = sy_fall[I_SCK];
  assign cs_rise      = sy_rise[I_CS];
  assign cs_fall      = sy_fall[I_CS];
  assign hold_rise    = sy_rise[I_HOLD];
  assign hold_fall    = sy_fall[I_HOLD];
  assign unused_edges = ^{sy_rise[I_SI], sy_fall[I_SI], sy_q[I_HOLD]};

  phase_e            phase_q;
  logic              holding_q;
  logic              active;
  logic              rx_shift, rx_done, tx_shift, tx_need;
  logic [7:0]        rx_byte, tx_load, nxt_q, data_q;
  logic [ADDR_W-1:0] addr_q;
  logic [AB_W-1:0]   abyte_q;
  logic              is_wr_q, wr_any_q, rd_pend_q;
  logic              rd_req_q, wen_set_q, wen_clr_q, sr_wr_q, pg_wr_q, pg_end_q;
  op_e               op;

  // pause edges count only with the serial clock low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    holding_q <= 1'b0;
    else if (cs_n_s)                holding_q <= 1'b0;
    else if (hold_fall && !sck_s)   holding_q <= 1'b1;
    else if (hold_rise && !sck_s)   holding_q <= 1'b0;
  end

  assign active   = !cs_n_s && !holding_q;
  assign rx_shift = active && sck_rise &&
                    (phase_q inside {PH_OPC, PH_ADDR, PH_STIN, PH_WRDATA});
  assign tx_shift = active && sck_fall && (phase_q inside {PH_RDOUT, PH_STOUT});
  assign tx_load  = (phase_q == PH_STOUT) ? status_i : nxt_q;
  assign op       = op_decode(rx_byte);

  spi_fe_rx #(.DW(8)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cs_fall),
    .shift_i (rx_shift),
    .bit_i   (si_s),
    .byte_o  (rx_byte),
    .done_o  (rx_done)
  );

  spi_fe_tx #(.DW(8)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cs_fall),
    .shift_i (tx_shift),
    .load_i  (tx_load),
    .so_o    (so_o),
    .need_o  (tx_need)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      addr_q    <= '0;
      abyte_q   <= '0;
      is_wr_q   <= 1'b0;
      wr_any_q  <= 1'b0;
      nxt_q     <= '0;
      data_q    <= '0;
      rd_pend_q <= 1'b0;
      rd_req_q  <= 1'b0;
      wen_set_q <= 1'b0;
      wen_clr_q <= 1'b0;
      sr_wr_q   <= 1'b0;
      pg_wr_q   <= 1'b0;
      pg_end_q  <= 1'b0;
    end else begin
      rd_req_q  <= 1'b0;
      wen_set_q <= 1'b0;
      wen_clr_q <= 1'b0;
      sr_wr_q   <= 1'b0;
      pg_wr_q   <= 1'b0;
      pg_end_q  <= 1'b0;
      rd_pend_q <= rd_req_q;
      if (rd_pend_q) nxt_q <= rd_data_i;

      if (cs_rise) begin
        if (phase_q == PH_WRDATA && wr_any_q) pg_end_q <= 1'b1;
        phase_q <= PH_IDLE;
      end else if (cs_fall) begin
        phase_q  <= PH_OPC;
        abyte_q  <= '0;
        wr_any_q <= 1'b0;
      end else begin
        // page-local increment after each write byte
        if (pg_wr_q) addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;

        if (rx_done) begin
          case (phase_q)
            PH_OPC: begin
              if (busy_i && op != OP_RDST) phase_q <= PH_SKIP;
              else begin
                case (op)
                  OP_SETWE: begin wen_set_q <= 1'b1; phase_q <= PH_SKIP; end
                  OP_CLRWE: begin wen_clr_q <= 1'b1; phase_q <= PH_SKIP; end
                  OP_RDST:  phase_q <= PH_STOUT;
                  OP_WRST:  phase_q <= PH_STIN;
                  OP_RDARR: begin is_wr_q <= 1'b0; phase_q <= PH_ADDR; end
                  OP_WRARR: begin is_wr_q <= 1'b1; phase_q <= PH_ADDR; end
                  default:  phase_q <= PH_LOCK;
                endcase
              end
            end
            PH_ADDR: begin
              addr_q  <= ADDR_W'({addr_q, rx_byte});
              abyte_q <= abyte_q + 1'b1;
              if (abyte_q == AB_W'(ADDR_BYTES - 1)) begin
                if (is_wr_q) phase_q <= PH_WRDATA;
                else begin
                  phase_q  <= PH_RDOUT;
                  rd_req_q <= 1'b1;
                end
              end
            end
            PH_STIN: begin
              sr_wr_q <= 1'b1;
              data_q  <= rx_byte;
              phase_q <= PH_SKIP;
            end
            PH_WRDATA: begin
              pg_wr_q  <= 1'b1;
              data_q   <= rx_byte;
              wr_any_q <= 1'b1;
            end
            default: ;
          endcase
        end

        // prefetch the following byte once the current one is loaded
        if (tx_need && phase_q == PH_RDOUT) begin
          addr_q   <= addr_q + 1'b1;
          rd_req_q <= 1'b1;
        end
      end
    end
  end

  assign so_oe_o   = active && (phase_q inside {PH_RDOUT, PH_STOUT});
  assign rd_req_o  = rd_req_q;
  assign addr_o    = addr_q;
  assign data_o    = data_q;
  assign wen_set_o = wen_set_q;
  assign wen_clr_o = wen_clr_q;
  assign sr_wr_o   = sr_wr_q;
  assign pg_wr_o   = pg_wr_q;
  assign pg_end_o  = pg_end_q;

  // R2: at most one command strobe per cycle
  a_r2_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wen_set_q, wen_clr_q, sr_wr_q, pg_wr_q, pg_end_q}));

  a_r4_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RDOUT && $past(phase_q == PH_RDOUT) && rd_req_q)
    |-> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  a_r7_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WRDATA && $past(phase_q == PH_WRDATA))
    |-> $stable(addr_q[ADDR_W-1:PAGE_W]));

  a_r8_lock_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_LOCK) |=> !(rd_req_q || wen_set_q || wen_clr_q || sr_wr_q || pg_wr_q));

  a_r9_busy_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_set_q || wen_clr_q || sr_wr_q) |-> !$past(busy_i));

  a_r10_hold_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (holding_q && $past(holding_q)) |-> ($stable(so_o) && !so_oe_o));

  a_r11_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_s && $past(cs_n_s)) |-> (phase_q == PH_IDLE && !so_oe_o));

endmodule

// File: tb/spi_mem_frontend_test.sv
module spi_mem_frontend_test;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0]  status = 8'h00, rd_data = 8'h00;
  logic        so_o, so_oe_o, rd_req_o, wen_set_o, wen_clr_o, sr_wr_o, pg_wr_o, pg_end_o;
  logic [16:0] addr_o;
  logic [7:0]  data_o;

  spi_mem_frontend uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .hold_ni(hold_n), .so_o(so_o), .so_oe_o(so_oe_o), .busy_i(busy),
    .status_i(status), .rd_req_o(rd_req_o), .addr_o(addr_o), .rd_data_i(rd_data),
    .data_o(data_o), .wen_set_o(wen_set_o), .wen_clr_o(wen_clr_o),
    .sr_wr_o(sr_wr_o), .pg_wr_o(pg_wr_o), .pg_end_o(pg_end_o)
  );

  function automatic logic [7:0] mem_f(input logic [16:0] a);
    return (a[7:0] ^ a[15:8]) + {a[16], 7'h1B};
  endfunction

  always_ff @(posedge clk_i) if (rd_req_o) rd_data <= mem_f(addr_o);

  int n_set = 0, n_clr = 0, n_sr = 0, n_pg = 0, n_end = 0;
  logic [7:0]  sr_last = 8'h00;
  logic [16:0] pg_a [16];
  logic [7:0]  pg_d [16];

  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (wen_set_o) n_set++;
      if (wen_clr_o) n_clr++;
      if (sr_wr_o) begin n_sr++; sr_last = data_o; end
      if (pg_end_o) n_end++;
      if (pg_wr_o) begin
        pg_a[n_pg % 16] = addr_o;
        pg_d[n_pg % 16] = data_o;
        n_pg++;
      end
    end
  end

  localparam int HALF = 6;
  int n_chk = 0, n_bad = 0;
  bit mode3 = 1'b0;
  bit finished = 1'b0;

  task automatic wclk(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cs_lo();
    sck = mode3;
    wclk(HALF);
    cs_n = 1'b0;
    wclk(HALF);
  endtask

  task automatic cs_hi();
    if (!mode3) sck = 1'b0;
    wclk(HALF);
    cs_n = 1'b1;
    wclk(2 * HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      si  = tx[i];
      wclk(HALF);
      rx[i] = so_o;
      sck = 1'b1;
      wclk(HALF);
    end
  endtask

  // pause inside bit hb with clock toggling and SI inverted during the pause
  task automatic xfer_hold(input logic [7:0] tx, output logic [7:0] rx, input int hb);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      si  = tx[i];
      if (i == hb) begin
        wclk(2);
        hold_n = 1'b0;
        wclk(HALF);
        chk("R10 output off in pause", so_oe_o, 1'b0);
        repeat (2) begin
          sck = 1'b1; si = ~tx[i]; wclk(HALF);
          sck = 1'b0; wclk(HALF);
        end
        chk("R10 output off after clocks in pause", so_oe_o, 1'b0);
        si = tx[i];
        hold_n = 1'b1;
        wclk(2);
      end
      wclk(HALF);
      rx[i] = so_o;
      sck = 1'b1;
      wclk(HALF);
    end
  endtask

  // {opcode, 24-bit address, byte count, mode}
  localparam int NV = 5;
  localparam logic [47:0] VEC [NV] = '{
    {8'h03, 24'h000010, 8'd3, 8'd0},
    {8'h0B, 24'h01FFFE, 8'd4, 8'd1},
    {8'h03, 24'hFE0005, 8'd2, 8'd0},
    {8'h0B, 24'h00ABCD, 8'd1, 8'd0},
    {8'h03, 24'h11FFFF, 8'd2, 8'd1}
  };

  initial begin : wdog
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0]  rx;
    logic [16:0] ea;
    int          base_set, base_clr, base_pg;

    wclk(5);
    chk("R11 reset output enable", so_oe_o, 1'b0);
    chk("R2 reset strobes", {wen_set_o, wen_clr_o, sr_wr_o, pg_wr_o, pg_end_o, rd_req_o}, 6'b0);
    rst_ni = 1'b1;
    wclk(5);

    // R1 R3 R4 R12: table of reads
    for (int v = 0; v < NV; v++) begin
      logic [47:0] e;
      e = VEC[v];
      mode3 = e[0];
      cs_lo();
      xfer(e[47:40], rx);
      chk("R12 output off during address", so_oe_o, 1'b0);
      xfer(e[39:32], rx);
      xfer(e[31:24], rx);
      xfer(e[23:16], rx);
      for (int k = 0; k < int'(e[15:8]); k++) begin
        xfer(8'h5A ^ 8'(k), rx);
        ea = e[32:16] + 17'(k);
        chk("R1 R3 R4 read byte", rx, mem_f(ea));
        chk("R12 output on during read", so_oe_o, 1'b1);
      end
      cs_hi();
      chk("R11 output off after release", so_oe_o, 1'b0);
    end
    mode3 = 1'b0;

    // R2: enable set/clear, bit 3 don't-care
    base_set = n_set; base_clr = n_clr;
    cs_lo(); xfer(8'h0E, rx); cs_hi();
    chk("R2 set strobe", n_set - base_set, 1);
    cs_lo(); xfer(8'h04, rx); cs_hi();
    chk("R2 clear strobe", n_clr - base_clr, 1);
    cs_lo(); xfer(8'h07, rx); xfer(8'h06, rx); cs_hi();
    chk("R2 R8 undefined low bits no strobe", n_set - base_set, 1);

    // R5: status stream
    mode3 = 1'b1;
    status = 8'hA6;
    cs_lo(); xfer(8'h05, rx);
    xfer(8'h00, rx); chk("R5 status byte 0", rx, 8'hA6);
    xfer(8'hFF, rx); chk("R5 status byte 1", rx, 8'hA6);
    cs_hi();
    mode3 = 1'b0;

    // R6: status write, second byte ignored
    cs_lo(); xfer(8'h01, rx); xfer(8'h8C, rx); xfer(8'h33, rx); cs_hi();
    chk("R6 status write count", n_sr, 1);
    chk("R6 status write data", sr_last, 8'h8C);

    // R7: page write wrapping inside page, bit 17 of address ignored (R3)
    base_pg = n_pg;
    cs_lo(); xfer(8'h0A, rx);
    xfer(8'h03, rx); xfer(8'h23, rx); xfer(8'h7E, rx);
    xfer(8'h11, rx); xfer(8'h22, rx); xfer(8'h33, rx);
    wclk(4);
    chk("R7 no end before release", n_end, 0);
    cs_hi();
    chk("R7 byte count", n_pg - base_pg, 3);
    chk("R7 addr 0", pg_a[base_pg % 16], 17'h1237E);
    chk("R7 addr 1", pg_a[(base_pg + 1) % 16], 17'h1237F);
    chk("R7 addr 2 page wrap", pg_a[(base_pg + 2) % 16], 17'h12300);
    chk("R7 data 2", pg_d[(base_pg + 2) % 16], 8'h33);
    chk("R7 end strobe", n_end, 1);

    // R9: busy filter
    busy = 1'b1;
    base_set = n_set;
    cs_lo(); xfer(8'h06, rx); cs_hi();
    chk("R9 set dropped while busy", n_set - base_set, 0);
    status = 8'hFF;
    cs_lo(); xfer(8'h05, rx); xfer(8'h00, rx); cs_hi();
    chk("R9 status read while busy", rx, 8'hFF);
    busy = 1'b0;

    // R8: lockout and recovery
    base_set = n_set; base_pg = n_pg;
    cs_lo(); xfer(8'h47, rx);
    chk("R8 output off after bad opcode", so_oe_o, 1'b0);
    xfer(8'h06, rx); xfer(8'h03, rx); xfer(8'h00, rx);
    chk("R8 output stays off", so_oe_o, 1'b0);
    cs_hi();
    chk("R8 no strobe in lockout", (n_set - base_set) + (n_pg - base_pg), 0);
    cs_lo(); xfer(8'h06, rx); cs_hi();
    chk("R8 recovery after select", n_set - base_set, 1);

    // R10: pause in the middle of a read byte and a write byte
    cs_lo(); xfer(8'h03, rx);
    xfer(8'h00, rx); xfer(8'h02, rx); xfer(8'h00, rx);
    xfer_hold(8'h00, rx, 2);
    chk("R10 read byte across pause", rx, mem_f(17'h00200));
    xfer(8'h00, rx);
    chk("R10 read after pause", rx, mem_f(17'h00201));
    cs_hi();
    base_pg = n_pg;
    cs_lo(); xfer(8'h02, rx);
    xfer(8'h00, rx); xfer(8'h40, rx); xfer(8'h10, rx);
    xfer_hold(8'hC3, rx, 4);
    cs_hi();
    chk("R10 write data across pause", pg_d[base_pg % 16], 8'hC3);
    chk("R10 write addr across pause", pg_a[base_pg % 16], 17'h04010);

    // R11: clocking with select high
    base_set = n_set;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = 8'h06 >> i; wclk(HALF);
      sck = 1'b1; wclk(HALF);
    end
    sck = 1'b0;
    wclk(2 * HALF);
    chk("R11 no strobe while deselected", n_set - base_set, 0);
    chk("R11 output off while deselected", so_oe_o, 1'b0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule